// File: doc/BRIEF.md
# Dual-Rate CAN FD Bit Timing Generator

This block divides the system clock into time quanta and walks each bit through its three segments: a one-quantum synchronization segment, segment 1 and segment 2. It raises a one-cycle strobe on every time quantum, a sample-point strobe on the last clock of segment 1, and a bit-boundary strobe on the last clock of segment 2. The protocol engine above it decides where to sample the receive line and when to shift the next bit.

Two configuration banks are held side by side. One bank serves the arbitration phase and one serves the faster data phase. A phase-select input chooses between them, and the choice is taken only at a bit boundary. Both banks drive one prescaler counter and one segment counter, so a switch of rate in the middle of a frame keeps the quantum grid continuous.

The block follows falling (recessive-to-dominant) edges on the receive line. A late edge stretches segment 1 and an early edge cuts segment 2, and both corrections are bounded by the synchronization jump width. When hard synchronization is requested, an edge restarts the bit at its synchronization segment. The receive input is assumed to be already synchronous to the system clock.

Top module: `cbt_timing_gen`

## Requirements
- R1: While `cfg_en_i` is 1, both banks capture their inputs, all counters are held cleared, and `tq_o`, `sample_o` and `bit_o` stay 0. While `cfg_en_i` is 0, changes on the configuration inputs have no effect on timing or on the error flags.
- R2: Every field is stored as its value minus one. `tq_o` pulses once every (prescaler field + 1) clocks, using the prescaler field of the active phase.
- R3: A bit of the active phase lasts 1 + (seg1 field + 1) + (seg2 field + 1) quanta. Its first quantum is the synchronization segment, and `bit_o` marks the final clock of the bit.
- R4: `sample_o` marks the final clock of segment 1. It comes (seg1 field + 2) quanta after the previous `bit_o` and (seg2 field + 1) quanta before the next one.
- R5: `data_phase_i` (1 = data bank, 0 = nominal bank) is sampled only in the cycle where `bit_o` is 1, and it governs the bits that follow. `cfg_en_i` returns the block to the nominal bank.
- R6: A falling edge of `rx_i` (1 = recessive) detected in segment 1 quantum q of the bit (q counted from 0 at the synchronization segment) lengthens segment 1 by min(q, SJW) quanta.
- R7: A falling edge detected in segment 2 cuts segment 2 by min(r - 1, SJW) quanta, where r is the number of segment 2 quanta still left including the current one. With the full cut the bit ends on the current quantum.
- R8: A falling edge in the synchronization segment, a rising edge, or a second falling edge within the same bit has no effect on timing.
- R9: While `hard_sync_i` is 1, a falling edge seen one clock after `rx_i` drops restarts the prescaler and the bit. The next `tq_o` follows (prescaler field + 2) clocks after the drop, and `sample_o` and `bit_o` follow 1 + (seg1 field + 2)·TQ and 1 + bit length clocks after the drop.
- R10: `nom_cfg_err_o` and `dat_cfg_err_o` are 1 exactly when the stored SJW of that bank exceeds the smaller of its segment 1 and segment 2 lengths.
- R11: `sample_o` and `bit_o` are only ever 1 in a cycle where `tq_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Configuration window: load banks, hold counters |
| data_phase_i | input | 1 | Phase select for following bits, 1 = data |
| hard_sync_i | input | 1 | Treat the next falling edge as hard synchronization |
| rx_i | input | 1 | Receive line, 1 = recessive |
| nom_brp_i | input | 8 | Nominal prescaler, value minus one |
| nom_seg1_i | input | 8 | Nominal segment 1, value minus one |
| nom_seg2_i | input | 7 | Nominal segment 2, value minus one |
| nom_sjw_i | input | 7 | Nominal jump width, value minus one |
| dat_brp_i | input | 8 | Data prescaler, value minus one |
| dat_seg1_i | input | 5 | Data segment 1, value minus one |
| dat_seg2_i | input | 4 | Data segment 2, value minus one |
| dat_sjw_i | input | 4 | Data jump width, value minus one |
| tq_o | output | 1 | Time-quantum strobe |
| sample_o | output | 1 | Sample-point strobe |
| bit_o | output | 1 | Bit-boundary strobe |
| nom_cfg_err_o | output | 1 | Nominal bank jump width too large |
| dat_cfg_err_o | output | 1 | Data bank jump width too large |

## Verification
The bench measures clock distances between strobes under random nominal settings, some of which break the jump-width rule. This shows whether the segment lengths and the error flag track the stored fields rather than the live inputs. Directed falling edges are placed in the synchronization segment, early and late in segment 1, and at two points of segment 2, once inside and once beyond the jump width, together with a second edge in one bit. This separates the stretch rule, the cut rule, the clipping and the one-per-bit rule. A phase switch requested in mid-bit, and a hard synchronization in mid-bit, show whether the rate change waits for the boundary and whether the restart rebuilds the prescaler grid.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  // Position of the bit walker inside the current bit.
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } cbt_seg_e;

endpackage

// File: rtl/cbt_cfg_bank.sv
// One register set for one phase: shadow fields captured while the
// configuration window is open, widened lengths and a jump-width check.
module cbt_cfg_bank #(
  parameter int unsigned BRP_W = 8,
  parameter int unsigned T1_W  = 8,
  parameter int unsigned T2_W  = 7,
  parameter int unsigned SJW_W = 7,
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [T1_W-1:0]  t1_i,
  input  logic [T2_W-1:0]  t2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic [LEN_W-1:0] brp_len_o,
  output logic [LEN_W-1:0] t1_len_o,
  output logic [LEN_W-1:0] t2_len_o,
  output logic [LEN_W-1:0] sjw_len_o,
  output logic             err_o
);

  logic [BRP_W-1:0] brp_q, brp_d;
  logic [T1_W-1:0]  t1_q,  t1_d;
  logic [T2_W-1:0]  t2_q,  t2_d;
  logic [SJW_W-1:0] sjw_q, sjw_d;
  logic [LEN_W-1:0] min_phase;

  always_comb begin
    brp_d = brp_q;
    t1_d  = t1_q;
    t2_d  = t2_q;
    sjw_d = sjw_q;
    if (cfg_en_i) begin
      brp_d = brp_i;
      t1_d  = t1_i;
      t2_d  = t2_i;
      sjw_d = sjw_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brp_q <= '0;
      t1_q  <= '0;
      t2_q  <= '0;
      sjw_q <= '0;
    end else begin
      brp_q <= brp_d;
      t1_q  <= t1_d;
      t2_q  <= t2_d;
      sjw_q <= sjw_d;
    end
  end

  assign brp_len_o = LEN_W'(brp_q) + LEN_W'(1);
  assign t1_len_o  = LEN_W'(t1_q)  + LEN_W'(1);
  assign t2_len_o  = LEN_W'(t2_q)  + LEN_W'(1);
  assign sjw_len_o = LEN_W'(sjw_q) + LEN_W'(1);

  always_comb begin
    min_phase = (t1_len_o < t2_len_o) ? t1_len_o : t2_len_o;
    err_o     = (sjw_len_o > min_phase);
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> ($stable(brp_q) && $stable(t1_q) && $stable(t2_q) && $stable(sjw_q))); // R1

endmodule

// File: rtl/cbt_prescaler.sv
// Single quantum divider shared by both phases.
module cbt_prescaler #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             tq_o
);

  logic [LEN_W-1:0] pc_q, pc_d;
  logic             wrap;

  always_comb begin
    wrap = (pc_q >= (len_i - LEN_W'(1)));
    tq_o = !clr_i && wrap;
    if (clr_i || wrap) begin
      pc_d = '0;
    end else begin
      pc_d = pc_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  AST_PC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q < len_i); // R2

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tq_o) |=> (pc_q == $past(pc_q) + LEN_W'(1))); // R2

endmodule

// File: rtl/cbt_bit_ctrl.sv
// Walks sync / segment 1 / segment 2 on quantum ticks and applies
// phase corrections for edges on the receive line.
module cbt_bit_ctrl
  import cbt_pkg::*;
#(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hsync_i,
  input  logic             resync_i,
  input  logic             tq_i,
  input  logic [LEN_W-1:0] t1_len_i,
  input  logic [LEN_W-1:0] t2_len_i,
  input  logic [LEN_W-1:0] sjw_len_i,
  output logic             sample_o,
  output logic             bit_o
);

  cbt_seg_e         seg_q, seg_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] ext_q, ext_d;
  logic [LEN_W-1:0] shr_q, shr_d;
  logic             done_q, done_d;

  logic [LEN_W-1:0] t1_eff, t2_eff;
  logic [LEN_W-1:0] late_err, early_err, ext_new, shr_new;
  logic             last1, last2;

  always_comb begin
    t1_eff    = t1_len_i + ext_q;
    t2_eff    = t2_len_i - shr_q;
    last1     = (seg_q == SEG_TS1) && (cnt_q >= (t1_eff - LEN_W'(1)));
    last2     = (seg_q == SEG_TS2) && (cnt_q >= (t2_eff - LEN_W'(1)));
    late_err  = cnt_q + LEN_W'(1);
    early_err = t2_len_i - LEN_W'(1) - cnt_q;
    ext_new   = (late_err  < sjw_len_i) ? late_err  : sjw_len_i;
    shr_new   = (early_err < sjw_len_i) ? early_err : sjw_len_i;
    sample_o  = tq_i && last1;
    bit_o     = tq_i && last2;
  end

  always_comb begin
    seg_d  = seg_q;
    cnt_d  = cnt_q;
    ext_d  = ext_q;
    shr_d  = shr_q;
    done_d = done_q;
    if (clr_i || hsync_i) begin
      seg_d  = SEG_SYNC;
      cnt_d  = '0;
      ext_d  = '0;
      shr_d  = '0;
      done_d = 1'b0;
    end else begin
      if (resync_i && !done_q && (seg_q != SEG_SYNC)) begin
        done_d = 1'b1;
        if (seg_q == SEG_TS1) begin
          ext_d = ext_new;
        end else begin
          shr_d = shr_new;
        end
      end
      if (tq_i) begin
        case (seg_q)
          SEG_SYNC: begin
            seg_d = SEG_TS1;
            cnt_d = '0;
          end
          SEG_TS1: begin
            if (last1) begin
              seg_d = SEG_TS2;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + LEN_W'(1);
            end
          end
          default: begin
            if (last2) begin
              seg_d  = SEG_SYNC;
              cnt_d  = '0;
              ext_d  = '0;
              shr_d  = '0;
              done_d = 1'b0;
            end else begin
              cnt_d = cnt_q + LEN_W'(1);
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      ext_q  <= '0;
      shr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      ext_q  <= ext_d;
      shr_q  <= shr_d;
      done_q <= done_d;
    end
  end

  AST_SYNC_ONE_TQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_i && (seg_q == SEG_SYNC) && !clr_i && !hsync_i) |=> (seg_q == SEG_TS1)); // R3

  AST_EXT_SJW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q <= sjw_len_i); // R6

  AST_SHR_SJW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shr_q <= sjw_len_i); // R7

  AST_ONE_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !tq_i && !clr_i && !hsync_i) |=> ($stable(ext_q) && $stable(shr_q))); // R8

  AST_SYNC_EDGE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resync_i && (seg_q == SEG_SYNC) && !tq_i && !clr_i && !hsync_i)
      |=> ($stable(ext_q) && $stable(shr_q))); // R8

endmodule

// File: rtl/cbt_timing_gen.sv
module cbt_timing_gen #(
  parameter int unsigned NBRP_W = 8,
  parameter int unsigned NT1_W  = 8,
  parameter int unsigned NT2_W  = 7,
  parameter int unsigned NSJW_W = 7,
  parameter int unsigned DBRP_W = 8,
  parameter int unsigned DT1_W  = 5,
  parameter int unsigned DT2_W  = 4,
  parameter int unsigned DSJW_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              data_phase_i,
  input  logic              hard_sync_i,
  input  logic              rx_i,
  input  logic [NBRP_W-1:0] nom_brp_i,
  input  logic [NT1_W-1:0]  nom_seg1_i,
  input  logic [NT2_W-1:0]  nom_seg2_i,
  input  logic [NSJW_W-1:0] nom_sjw_i,
  input  logic [DBRP_W-1:0] dat_brp_i,
  input  logic [DT1_W-1:0]  dat_seg1_i,
  input  logic [DT2_W-1:0]  dat_seg2_i,
  input  logic [DSJW_W-1:0] dat_sjw_i,
  output logic              tq_o,
  output logic              sample_o,
  output logic              bit_o,
  output logic              nom_cfg_err_o,
  output logic              dat_cfg_err_o
);

  // Segment 1 plus the widest stretch must fit; also covers the prescaler.
  localparam int unsigned LEN_W = ((NT1_W > NBRP_W) ? NT1_W : NBRP_W) + 2;

  // Reset: asserted at once, released on the clock.
  logic rst_meta_q, rst_sync_q, rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n = rst_sync_q;

  // Falling-edge detect on the receive line.
  logic rx_q1, rx_q2, fall, hsync_evt, resync_evt;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rx_q1 <= 1'b1;
      rx_q2 <= 1'b1;
    end else begin
      rx_q1 <= rx_i;
      rx_q2 <= rx_q1;
    end
  end

  always_comb begin
    fall       = rx_q2 && !rx_q1 && !cfg_en_i;
    hsync_evt  = fall && hard_sync_i;
    resync_evt = fall && !hard_sync_i;
  end

  // Phase register, updated only on a bit boundary.
  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (cfg_en_i) begin
      phase_d = 1'b0;
    end else if (bit_o) begin
      phase_d = data_phase_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // Two banks of different field widths.
  logic [LEN_W-1:0] n_brp, n_t1, n_t2, n_sjw;
  logic [LEN_W-1:0] d_brp, d_t1, d_t2, d_sjw;

  cbt_cfg_bank #(
    .BRP_W(NBRP_W), .T1_W(NT1_W), .T2_W(NT2_W), .SJW_W(NSJW_W), .LEN_W(LEN_W)
  ) i_nom_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .cfg_en_i  (cfg_en_i),
    .brp_i     (nom_brp_i),
    .t1_i      (nom_seg1_i),
    .t2_i      (nom_seg2_i),
    .sjw_i     (nom_sjw_i),
    .brp_len_o (n_brp),
    .t1_len_o  (n_t1),
    .t2_len_o  (n_t2),
    .sjw_len_o (n_sjw),
    .err_o     (nom_cfg_err_o)
  );

  cbt_cfg_bank #(
    .BRP_W(DBRP_W), .T1_W(DT1_W), .T2_W(DT2_W), .SJW_W(DSJW_W), .LEN_W(LEN_W)
  ) i_dat_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .cfg_en_i  (cfg_en_i),
    .brp_i     (dat_brp_i),
    .t1_i      (dat_seg1_i),
    .t2_i      (dat_seg2_i),
    .sjw_i     (dat_sjw_i),
    .brp_len_o (d_brp),
    .t1_len_o  (d_t1),
    .t2_len_o  (d_t2),
    .sjw_len_o (d_sjw),
    .err_o     (dat_cfg_err_o)
  );

  logic [LEN_W-1:0] act_brp, act_t1, act_t2, act_sjw;

  always_comb begin
    act_brp = phase_q ? d_brp : n_brp;
    act_t1  = phase_q ? d_t1  : n_t1;
    act_t2  = phase_q ? d_t2  : n_t2;
    act_sjw = phase_q ? d_sjw : n_sjw;
  end

  cbt_prescaler #(.LEN_W(LEN_W)) i_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (cfg_en_i || hsync_evt),
    .len_i  (act_brp),
    .tq_o   (tq_o)
  );

  cbt_bit_ctrl #(.LEN_W(LEN_W)) i_bit_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_i     (cfg_en_i),
    .hsync_i   (hsync_evt),
    .resync_i  (resync_evt),
    .tq_i      (tq_o),
    .t1_len_i  (act_t1),
    .t2_len_i  (act_t2),
    .sjw_len_i (act_sjw),
    .sample_o  (sample_o),
    .bit_o     (bit_o)
  );

  AST_QUIET_IN_CFG: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_en_i |-> (!tq_o && !sample_o && !bit_o)); // R1

  AST_PHASE_AT_BIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!bit_o && !cfg_en_i) |=> $stable(phase_q)); // R5

  AST_STROBE_ON_TQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sample_o || bit_o) |-> tq_o); // R11

  AST_NO_DOUBLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(sample_o && bit_o)); // R4

endmodule

// File: tb/test_cbt_timing_gen.sv
module test_cbt_timing_gen;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       cfg_en, dphase, hsync, rx;
  logic [7:0] nbrp, nseg1, dbrp;
  logic [6:0] nseg2, nsjw;
  logic [4:0] dseg1;
  logic [3:0] dseg2, dsjw;
  logic       tq_o, sample_o, bit_o, nerr, derr;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int misalign = 0;
  bit run_mon = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cbt_timing_gen i_cbt_timing_gen (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .cfg_en_i      (cfg_en),
    .data_phase_i  (dphase),
    .hard_sync_i   (hsync),
    .rx_i          (rx),
    .nom_brp_i     (nbrp),
    .nom_seg1_i    (nseg1),
    .nom_seg2_i    (nseg2),
    .nom_sjw_i     (nsjw),
    .dat_brp_i     (dbrp),
    .dat_seg1_i    (dseg1),
    .dat_seg2_i    (dseg2),
    .dat_sjw_i     (dsjw),
    .tq_o          (tq_o),
    .sample_o      (sample_o),
    .bit_o         (bit_o),
    .nom_cfg_err_o (nerr),
    .dat_cfg_err_o (derr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (run_mon && (sample_o || bit_o) && !tq_o) misalign++;
  end

  always @(posedge clk) begin
    if (cyc >= 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int bit_quanta(input int s1f, input int s2f);
    return 3 + s1f + s2f;
  endfunction

  function automatic int cfg_bad(input int s1f, input int s2f, input int sjwf);
    return ((sjwf + 1) > imin(s1f + 1, s2f + 1)) ? 1 : 0;
  endfunction

  // Bit length in quanta after a falling edge in quantum q (q=0 is sync).
  function automatic int resync_len(input int q, input int s1f, input int s2f, input int sjwf);
    int t1 = s1f + 1;
    int t2 = s2f + 1;
    int sj = sjwf + 1;
    if (q == 0) return 1 + t1 + t2;
    if (q <= t1) return 1 + t1 + t2 + imin(q, sj);
    return 1 + t1 + t2 - imin(t2 - 1 - (q - 1 - t1), sj);
  endfunction

  function automatic int resync_smp(input int q, input int s1f, input int sjwf);
    int t1 = s1f + 1;
    if (q >= 1 && q <= t1) return 1 + t1 + imin(q, sjwf + 1);
    return 1 + t1;
  endfunction

  task automatic wait_bit(output int c);
    @(negedge clk);
    while (!bit_o) @(negedge clk);
    c = cyc;
  endtask

  task automatic wait_smp(output int c);
    @(negedge clk);
    while (!sample_o) @(negedge clk);
    c = cyc;
  endtask

  task automatic wait_tq(output int c);
    @(negedge clk);
    while (!tq_o) @(negedge clk);
    c = cyc;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic cfg_load();
    @(negedge clk);
    cfg_en = 1'b1;
    repeat (3) @(negedge clk);
    cfg_en = 1'b0;
  endtask

  // Base nominal setting: TQ = 4 clocks, seg1 10, seg2 5, SJW 3.
  localparam int NB = 3, NS1 = 9, NS2 = 4, NSJ = 2;
  localparam int TQN = NB + 1;

  task automatic set_base();
    nbrp = 8'(NB); nseg1 = 8'(NS1); nseg2 = 7'(NS2); nsjw = 7'(NSJ);
    dbrp = 8'd1; dseg1 = 5'd4; dseg2 = 4'd2; dsjw = 4'd1;
  endtask

  task automatic resync_case(input string tag, input int q, input bit meas_smp);
    int b0, s, b1;
    wait_bit(b0);
    wait_cyc(b0 + q * TQN + 1);
    rx = 1'b0;
    if (meas_smp) begin
      wait_smp(s);
      chk(tag, s - b0, resync_smp(q, NS1, NSJ) * TQN);
    end
    wait_bit(b1);
    chk(tag, b1 - b0, resync_len(q, NS1, NS2, NSJ) * TQN);
    rx = 1'b1;
  endtask

  initial begin
    int b0, b1, b2, b3, b4, s, t0, t1, n, cnt;
    rst_ni = 1'b0; cfg_en = 1'b1; dphase = 1'b0; hsync = 1'b0; rx = 1'b1;
    set_base();
    void'($urandom(32'd20240611));

    // Reset state
    repeat (3) @(negedge clk);
    chk("R1 reset tq", int'(tq_o), 0);
    chk("R1 reset strobes", int'(sample_o | bit_o), 0);
    chk("R10 reset flags", int'(nerr | derr), 0);
    rst_ni = 1'b1;
    run_mon = 1'b1;

    // Quiet while the configuration window is open
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tq_o || sample_o || bit_o) cnt++;
    end
    chk("R1 quiet in cfg", cnt, 0);
    cfg_en = 1'b0;

    // Nominal grid
    wait_tq(t0); wait_tq(t1);
    chk("R2 tq period", t1 - t0, TQN);
    wait_bit(b0); wait_smp(s); wait_bit(b1);
    chk("R4 bit to sample", s - b0, (NS1 + 2) * TQN);
    chk("R4 sample to bit", b1 - s, (NS2 + 1) * TQN);
    chk("R3 bit length", b1 - b0, bit_quanta(NS1, NS2) * TQN);

    // Inputs changed outside the window are ignored
    nseg2 = 7'd0; nsjw = 7'd5; nbrp = 8'd0;
    wait_bit(b0); wait_bit(b1);
    chk("R1 ignored length", b1 - b0, bit_quanta(NS1, NS2) * TQN);
    chk("R1 ignored flag", int'(nerr), 0);
    set_base();

    // Phase switch requested mid-bit
    wait_bit(b0);
    wait_cyc(b0 + 10);
    dphase = 1'b1;
    wait_bit(b1);
    chk("R5 current bit nominal", b1 - b0, bit_quanta(NS1, NS2) * TQN);
    wait_bit(b2);
    chk("R5 data bit", b2 - b1, bit_quanta(4, 2) * 2);
    wait_tq(t0); wait_tq(t1);
    chk("R2 data tq period", t1 - t0, 2);
    dphase = 1'b0;
    wait_bit(b3);
    chk("R5 still data", b3 - b2, bit_quanta(4, 2) * 2);
    wait_bit(b4);
    chk("R5 back nominal", b4 - b3, bit_quanta(NS1, NS2) * TQN);

    // Resynchronization corner cases
    resync_case("R8 sync edge", 0, 1'b1);
    resync_case("R6 late small", 2, 1'b1);
    resync_case("R6 late clipped", 8, 1'b1);
    resync_case("R7 early clipped", 11, 1'b0);
    resync_case("R7 early partial", 14, 1'b0);

    // Second edge in one bit
    wait_bit(b0);
    wait_cyc(b0 + 2 * TQN + 1); rx = 1'b0;
    wait_cyc(b0 + 5 * TQN + 1); rx = 1'b1;
    wait_cyc(b0 + 13 * TQN + 1); rx = 1'b0;
    wait_bit(b1);
    chk("R8 second edge", b1 - b0, resync_len(2, NS1, NS2, NSJ) * TQN);
    rx = 1'b1;
    wait_bit(b0); wait_bit(b1);
    chk("R8 rising edge", b1 - b0, bit_quanta(NS1, NS2) * TQN);

    // Hard synchronization mid-bit
    wait_bit(b0);
    hsync = 1'b1;
    n = b0 + 30;
    wait_cyc(n);
    rx = 1'b0;
    wait_tq(t0);
    chk("R9 first tq", t0 - n, NB + 2);
    wait_smp(s);
    chk("R9 sample", s - n, 1 + (NS1 + 2) * TQN);
    wait_bit(b1);
    chk("R9 bit", b1 - n, 1 + bit_quanta(NS1, NS2) * TQN);
    rx = 1'b1; hsync = 1'b0;

    // Random nominal settings
    for (int it = 0; it < 16; it++) begin
      int rb, r1, r2, rj;
      rb = int'($urandom_range(4, 0));
      r1 = int'($urandom_range(24, 1));
      r2 = int'($urandom_range(12, 0));
      rj = int'($urandom_range(15, 0));
      nbrp = 8'(rb); nseg1 = 8'(r1); nseg2 = 7'(r2); nsjw = 7'(rj);
      cfg_load();
      chk("R10 random flag", int'(nerr), cfg_bad(r1, r2, rj));
      wait_bit(b0); wait_smp(s); wait_bit(b1);
      chk("R3 random length", b1 - b0, bit_quanta(r1, r2) * (rb + 1));
      chk("R4 random sample", b1 - s, (r2 + 1) * (rb + 1));
    end

    // Directed configuration check
    set_base();
    nseg2 = 7'd2; nsjw = 7'd3;
    dseg1 = 5'd1; dseg2 = 4'd5; dsjw = 4'd2;
    cfg_load();
    chk("R10 nominal bad", int'(nerr), 1);
    chk("R10 data bad", int'(derr), 1);
    set_base();
    nseg2 = 7'd2; nsjw = 7'd2;
    cfg_load();
    chk("R10 nominal edge ok", int'(nerr), 0);
    chk("R10 data ok", int'(derr), 0);

    repeat (50) @(negedge clk);
    chk("R11 strobe alignment", misalign, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule